// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

This block watches one tearing-effect pin driven by a display panel and decides when a waiting frame transfer may begin. The panel signals both frame starts and line starts on the same wire, and the block tells them apart purely by how long each pulse stays at its active level. A pulse that stays active long enough is a vertical sync. A pulse that ends after at least the programmed horizontal width, but before the vertical threshold, is a horizontal sync. Anything shorter is a glitch and is ignored.

Pulse widths are counted in ticks of a divided clock. The divided clock is supplied as a one-cycle `tick_en` strobe, so one tick lasts from 1 to 8 system clocks. The pin first passes through a short synchronizer chain. Configuration comes as a 30-bit tearing word plus a separate detector-enable bit. In vertical-only mode, every vertical sync produces a match. In line mode, a line counter is cleared by each vertical sync and advanced by each horizontal sync, and a match fires once per frame when the count reaches the programmed target line. The match output is active low, because it feeds a falling-edge interrupt.

Top module: `te_sync_detector`

## Requirements
- R1: The `tear_cfg` word is decoded as follows:
  - bits 2:0 give the horizontal width minus one, in ticks (1 to 8 ticks);
  - bits 14:3 give the vertical threshold as (ticks/8)-1, so the threshold is (field+1)*8 ticks;
  - bits 25:15 give the target line;
  - bits 27:26 give the mode;
  - bit 28 inverts the vertical polarity;
  - bit 29 inverts the horizontal polarity.
- R2: The detector runs only while `det_enable` is 1 and the mode is 2 or 3. In any other case, from the next clock on, `match_n` is 1, the width counters and line counter are zero, and no frame is armed.
- R3: A vertical sync is recognised on the tick at which a pulse's active width reaches the vertical threshold. It is recognised once per pulse.
- R4: A horizontal sync is recognised on the first tick at which the pin is inactive after a pulse whose active width was at least the horizontal width and below the vertical threshold. Shorter pulses have no effect.
- R5: The active level of the pin is high. For the vertical measurement it is low when bit 28 is set. For the horizontal measurement it is low when bit 29 is set.
- R6: In mode 3, every vertical sync produces a match.
- R7: In mode 2:
  - a vertical sync clears the line count to 0 and arms the frame;
  - a horizontal sync adds one to the count, saturating at its maximum;
  - a match fires when an event brings the count to the target line, so target 0 matches on the vertical sync itself;
  - there is no match before the first vertical sync, and at most one match per armed frame.
- R8: `match_n` goes low in the clock after the tick carrying the match event. It stays low until the next tick, which makes it exactly one tick long.
- R9: Widths are measured only on cycles where `tick_en` is 1. The pin is sampled through `SYNC_STAGES` flip-flops.
- R10: The width counters saturate at their all-ones value instead of wrapping. A very long pulse yields only one vertical sync.
- R11: After reset, `match_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe marking each divided-clock tick |
| te_pin | input | 1 | Raw tearing-effect pin from the panel |
| det_enable | input | 1 | Detector enable |
| tear_cfg | input | 30 | Tearing configuration word (fields in R1) |
| match_n | output | 1 | Active-low match pulse for the interrupt controller |

## Verification
The bench goes after these corner cases:
- **Width boundaries.** Pulses exactly one tick short of the vertical threshold and exactly at it are both sent. A detector with an off-by-one compare would swap a frame start for a line start.
- **Glitches in line mode.** Sub-width glitches are placed inside a line-mode frame. A design that counted them would match lines early.
- **Line pulses before any frame start.** A design that skipped arming would fire on them.
- **Very long pulse.** A pulse longer than the counter range is sent, and a wrapping counter would report a second frame start. With a divided tick, a match lasting one clock instead of one tick is exposed.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

   // Field positions inside the tearing configuration word.
   localparam int HW_LSB   = 0;
   localparam int HW_W     = 3;
   localparam int VTH_LSB  = 3;
   localparam int VTH_W    = 12;
   localparam int LINE_LSB = 15;
   localparam int TGT_W    = 11;
   localparam int MODE_LSB = 26;
   localparam int VINV_BIT = 28;
   localparam int HINV_BIT = 29;
   localparam int CFG_W    = 30;

   typedef enum logic [1:0] {
      TE_OFF   = 2'd0,
      TE_RSVD  = 2'd1,
      TE_LINE  = 2'd2,
      TE_VSYNC = 2'd3
   } te_mode_e;

endpackage

// File: rtl/te_pin_sync.sv
module te_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic pin_sync
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("te_pin_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 1'b0;
            else        ff_q <= pin_raw;
         end
         assign pin_sync = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[STAGES-2:0], pin_raw};
         end
         assign pin_sync = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
   parameter int CNT_W   = 16,
   parameter bit IS_VERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             act,
   input  logic [CNT_W-1:0] vs_ticks,
   input  logic [CNT_W-1:0] hs_ticks,
   output logic             evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] width_q;

   // Saturating active-width counter, advanced only on ticks.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
      end else if (clr) begin
         width_q <= '0;
      end else if (tick) begin
         if (!act)                    width_q <= '0;
         else if (width_q != CNT_MAX) width_q <= width_q + CNT_ONE;
      end
   end

   generate
      if (IS_VERT) begin : g_vert
         // Fires on the tick at which the active width reaches the threshold.
         assign evt = !clr && tick && act && (width_q == vs_ticks - CNT_ONE);
      end else begin : g_horz
         // Fires on the first inactive tick after a pulse of qualifying width.
         assign evt = !clr && tick && !act &&
                      (width_q >= hs_ticks) && (width_q < vs_ticks);
      end
   endgenerate

endmodule

// File: rtl/te_line_matcher.sv
module te_line_matcher
   import te_sync_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              vs_evt,
   input  logic              hs_evt,
   input  te_mode_e          mode,
   input  logic [LINE_W-1:0] target,
   output logic              match_q,
   output logic [LINE_W-1:0] line_q
);

   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

   logic              armed_q;
   logic              armed_eff;
   logic [LINE_W-1:0] line_nxt;
   logic              hit;

   always_comb begin
      armed_eff = vs_evt ? 1'b1 : armed_q;
      if (vs_evt)                            line_nxt = '0;
      else if (hs_evt && line_q != LINE_MAX) line_nxt = line_q + LINE_ONE;
      else                                   line_nxt = line_q;

      hit = 1'b0;
      if (mode == TE_VSYNC)
         hit = vs_evt;
      else if (mode == TE_LINE)
         hit = (vs_evt || hs_evt) && armed_eff && (line_nxt == target);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         line_q  <= '0;
         armed_q <= 1'b0;
      end else if (clr) begin
         match_q <= 1'b0;
         line_q  <= '0;
         armed_q <= 1'b0;
      end else if (tick) begin
         match_q <= hit;
         line_q  <= line_nxt;
         armed_q <= hit ? 1'b0 : armed_eff;
      end
   end

endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector
   import te_sync_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16,
   parameter int LINE_W      = TGT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             te_pin,
   input  logic             det_enable,
   input  logic [CFG_W-1:0] tear_cfg,
   output logic             match_n
);

   generate
      if (CNT_W < 16) begin : g_bad_cnt
         $error("te_sync_detector: CNT_W must hold a 32768-tick threshold");
      end
      if (LINE_W != TGT_W) begin : g_bad_line
         $error("te_sync_detector: LINE_W must match the target field width");
      end
   endgenerate

   // Field decode
   logic [HW_W-1:0]   hw_f;
   logic [VTH_W-1:0]  vth_f;
   logic [LINE_W-1:0] tgt_f;
   te_mode_e          mode_f;
   logic              vinv_f, hinv_f;

   assign hw_f   = tear_cfg[HW_LSB +: HW_W];
   assign vth_f  = tear_cfg[VTH_LSB +: VTH_W];
   assign tgt_f  = tear_cfg[LINE_LSB +: LINE_W];
   assign mode_f = te_mode_e'(tear_cfg[MODE_LSB +: 2]);
   assign vinv_f = tear_cfg[VINV_BIT];
   assign hinv_f = tear_cfg[HINV_BIT];

   logic [CNT_W-1:0] vs_ticks, hs_ticks;
   assign vs_ticks = CNT_W'((32'(vth_f) + 32'd1) << 3);
   assign hs_ticks = CNT_W'(32'(hw_f) + 32'd1);

   logic run, clr;
   assign run = det_enable && (mode_f == TE_LINE || mode_f == TE_VSYNC);
   assign clr = !run;

   logic pin_s;
   te_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (te_pin),
      .pin_sync (pin_s)
   );

   // Channel 0 measures with vertical polarity, channel 1 with horizontal.
   logic [1:0] act_ch;
   logic [1:0] evt_ch;
   assign act_ch[0] = pin_s ^ vinv_f;
   assign act_ch[1] = pin_s ^ hinv_f;

   for (genvar gi = 0; gi < 2; gi++) begin : g_chan
      te_pulse_classifier #(.CNT_W(CNT_W), .IS_VERT(gi == 0)) u_cls (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .tick     (tick_en),
         .act      (act_ch[gi]),
         .vs_ticks (vs_ticks),
         .hs_ticks (hs_ticks),
         .evt      (evt_ch[gi])
      );
   end

   logic vs_evt, hs_evt;
   assign vs_evt = evt_ch[0];
   assign hs_evt = evt_ch[1];

   logic              match_q;
   logic [LINE_W-1:0] line_cnt;

   te_line_matcher #(.LINE_W(LINE_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .tick    (tick_en),
      .vs_evt  (vs_evt),
      .hs_evt  (hs_evt),
      .mode    (mode_f),
      .target  (tgt_f),
      .match_q (match_q),
      .line_q  (line_cnt)
   );

   assign match_n = !match_q;

endmodule

// File: rtl/te_sync_detector_chk.sv
module te_sync_detector_chk #(
   parameter int LINE_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              det_enable,
   input logic [29:0]       tear_cfg,
   input logic              match_n,
   input logic              vs_evt,
   input logic              hs_evt,
   input logic [LINE_W-1:0] line_cnt
);

   logic [1:0] mode_c;
   logic       run_c;
   assign mode_c = tear_cfg[27:26];
   assign run_c  = det_enable && mode_c[1];

   // R2
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_c |=> match_n);

   // R8
   fall_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_n) |-> $past(tick_en));

   // R8
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && run_c) |=> $stable(match_n));

   // R6
   vsync_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && mode_c == 2'd3 && vs_evt) |=> !match_n);

   // R7
   line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && vs_evt) |=> line_cnt == '0);

   // R7
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && hs_evt && !vs_evt && line_cnt != '1) |=>
         line_cnt == $past(line_cnt) + LINE_W'(1));

   // R7
   no_spurious_line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && mode_c == 2'd2 && tick_en && !vs_evt && !hs_evt) |=> match_n);

   // R3
   evt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_evt || hs_evt) |-> tick_en);

endmodule

bind te_sync_detector te_sync_detector_chk #(.LINE_W(LINE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .det_enable (det_enable),
   .tear_cfg   (tear_cfg),
   .match_n    (match_n),
   .vs_evt     (vs_evt),
   .hs_evt     (hs_evt),
   .line_cnt   (line_cnt)
);

// File: tb/te_sync_detector_tb_top.sv
module te_sync_detector_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int CNT_MAXV   = 65535;
   localparam int LINE_MAXV  = 2047;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        te_pin = 1'b0;
   logic        det_enable = 1'b0;
   logic [29:0] tear_cfg = '0;
   logic        match_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   te_sync_detector #(.SYNC_STAGES(SYNC)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .te_pin     (te_pin),
      .det_enable (det_enable),
      .tear_cfg   (tear_cfg),
      .match_n    (match_n)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Tick generator
   int tick_div = 1;
   int tphase   = 0;
   always @(negedge clk) begin
      tick_en = (tphase == 0);
      tphase  = (tphase + 1 >= tick_div) ? 0 : tphase + 1;
   end

   // Behavioural reference model
   int spipe [SYNC];
   int vc, hc, line, armed, mq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC; i++) spipe[i] = 0;
         vc = 0; hc = 0; line = 0; armed = 0; mq = 0;
      end else begin
         int p, mode, vth, hsw, tgt, vsw, va, ha, vev, hev, aeff, lnew, hit;
         p = spipe[SYNC-1];
         for (int i = SYNC-1; i > 0; i--) spipe[i] = spipe[i-1];
         spipe[0] = te_pin;
         mode = tear_cfg[27:26];
         hsw  = tear_cfg[2:0] + 1;
         vth  = (tear_cfg[14:3] + 1) * 8;
         tgt  = tear_cfg[25:15];
         if (!(det_enable && (mode == 2 || mode == 3))) begin
            vc = 0; hc = 0; line = 0; armed = 0; mq = 0;
         end else if (tick_en) begin
            va  = p ^ tear_cfg[28];
            ha  = p ^ tear_cfg[29];
            vev = (va && vc == vth - 1);
            hev = (!ha && hc >= hsw && hc < vth);
            vc  = va ? ((vc < CNT_MAXV) ? vc + 1 : vc) : 0;
            hc  = ha ? ((hc < CNT_MAXV) ? hc + 1 : hc) : 0;
            aeff = vev ? 1 : armed;
            if (vev)      lnew = 0;
            else if (hev) lnew = (line < LINE_MAXV) ? line + 1 : line;
            else          lnew = line;
            if (mode == 3) hit = vev;
            else           hit = (vev || hev) && aeff && (lnew == tgt);
            line  = lnew;
            armed = hit ? 0 : aeff;
            mq    = hit;
         end
      end
   end

   // Per-cycle comparison and match statistics
   int n_match  = 0;
   int low_clks = 0;
   logic prev_m = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 model", int'(match_n), mq ? 0 : 1);
         if (!match_n && prev_m) n_match++;
         if (!match_n) low_clks++;
      end
      prev_m = match_n;
   end

   task automatic cfg(int hw, int vthf, int tgt, int mode, int vinv, int hinv);
      @(negedge clk);
      tear_cfg = {1'(hinv), 1'(vinv), 2'(mode), 11'(tgt), 12'(vthf), 3'(hw)};
   endtask

   task automatic pulse(int lvl, int w, int gap);
      @(negedge clk);
      te_pin = 1'(lvl);
      repeat (w) @(negedge clk);
      te_pin = 1'(!lvl);
      repeat (gap - 1) @(negedge clk);
   endtask

   task automatic restart(int en);
      @(negedge clk);
      det_enable = 1'b0;
      repeat (3) @(negedge clk);
      det_enable = 1'(en);
      n_match  = 0;
      low_clks = 0;
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset match_n", int'(match_n), 1);

      // R6 mode 3: vsync only, hs width 3, vs threshold 16
      cfg(2, 1, 0, 3, 0, 0);
      restart(1);
      pulse(1, 20, 10);
      repeat (3) pulse(1, 5, 10);
      pulse(1, 20, 10);
      pulse(1, 2, 10);
      chk("R6 vsync-only matches", n_match, 2);

      // R3 exact threshold boundary: 15 ticks is not vertical, 16 is
      restart(1);
      pulse(1, 15, 10);
      chk("R3 width 15 below threshold", n_match, 0);
      pulse(1, 16, 10);
      chk("R3 width 16 at threshold", n_match, 1);

      // R7 mode 2 target 2, two frames
      cfg(2, 1, 2, 2, 0, 0);
      restart(1);
      pulse(1, 20, 10);
      repeat (4) pulse(1, 5, 10);
      pulse(1, 20, 10);
      repeat (3) pulse(1, 5, 10);
      chk("R7 line match once per frame", n_match, 2);

      // R7 no vsync yet: line pulses alone never match
      restart(1);
      repeat (5) pulse(1, 5, 10);
      chk("R7 no match before first vsync", n_match, 0);

      // R4 glitches inside a frame are ignored
      restart(1);
      pulse(1, 20, 10);
      repeat (3) pulse(1, 2, 10);
      pulse(1, 5, 10);
      chk("R4 glitches not counted", n_match, 0);
      pulse(1, 5, 10);
      chk("R4 second line reaches target", n_match, 1);

      // R7 target 0 matches on the vsync itself
      cfg(2, 1, 0, 2, 0, 0);
      restart(1);
      pulse(1, 20, 10);
      pulse(1, 5, 10);
      pulse(1, 20, 10);
      chk("R7 target zero on vsync", n_match, 2);

      // R2 disabled by enable bit, then by mode 0
      cfg(2, 1, 0, 3, 0, 0);
      restart(0);
      repeat (2) pulse(1, 20, 10);
      chk("R2 enable low", n_match, 0);
      cfg(2, 1, 0, 0, 0, 0);
      restart(1);
      repeat (2) pulse(1, 20, 10);
      chk("R2 mode zero", n_match, 0);

      // R5 inverted polarity: idle high, pulses low
      cfg(2, 1, 0, 3, 1, 1);
      @(negedge clk) te_pin = 1'b1;
      restart(1);
      repeat (5) @(negedge clk);
      pulse(0, 20, 10);
      pulse(0, 5, 10);
      pulse(0, 20, 10);
      chk("R5 inverted polarity vsync", n_match, 2);

      // R1 field positions: threshold field 3 -> 32 ticks, hs field 5 -> 6 ticks
      cfg(5, 3, 1, 2, 0, 0);
      @(negedge clk) te_pin = 1'b0;
      restart(1);
      repeat (5) @(negedge clk);
      pulse(1, 20, 10);
      pulse(1, 40, 10);
      pulse(1, 5, 10);
      chk("R1 narrow line below hs width", n_match, 0);
      pulse(1, 7, 10);
      chk("R1 line at hs width hits target 1", n_match, 1);

      // R9 divided tick: 4 clocks per tick, threshold 16 ticks
      cfg(2, 1, 0, 3, 0, 0);
      tick_div = 4;
      restart(1);
      pulse(1, 60, 40);
      chk("R9 60 clocks is 15 ticks", n_match, 0);
      pulse(1, 70, 40);
      chk("R9 70 clocks exceeds threshold", n_match, 1);
      // R8 match lasts exactly one tick
      chk("R8 low clocks per match", low_clks, 4);

      // R10 saturation: very long pulse gives one vsync only
      tick_div = 1;
      restart(1);
      pulse(1, 65600, 20);
      chk("R10 long pulse single vsync", n_match, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule